// File: doc/BRIEF.md
# Interrupt Request Front End

This block sits between a processor core and its two interrupt pins. The non-maskable line is asynchronous and edge-triggered. It is synchronized and then checked for a minimum low width followed by a minimum high width before it counts as an edge. One qualified edge is held pending while an earlier non-maskable interrupt is still in service. Service ends when the core pulses its return-from-interrupt strobe. A non-maskable interrupt is handed to the core with the fixed vector 2 and causes no bus traffic.

The maskable line is a synchronized level, and it is honoured only while the core's interrupt-enable flag is set. When it is taken, the block asks the bus engine for two interrupt-acknowledge cycles in turn. Each request is held until the engine answers with a done strobe, and there is one idle cycle between the two requests. The 8-bit vector is taken from the data lines on the done strobe of the second cycle. Every delivered vector appears with a valid pulse lasting one clock. While the bus is granted to another master, no request is started and no non-maskable interrupt is delivered. Edges that arrive during that time are kept until the grant ends.

Top module: `irq_front_end`

## Requirements
- R1: While reset is held and right after it is released, `ack_req_o` and `vec_valid_o` are 0.
- R2: A non-maskable input that is low for at least 8 clocks and then high for at least 8 clocks causes exactly one delivery, with `vec_o` = 2, `vec_is_nmi_o` = 1 and no rise of `ack_req_o`.
- R3: A high phase shorter than 8 clocks, or a high phase that follows a low phase shorter than 8 clocks, causes no delivery.
- R4: After a non-maskable delivery, no further non-maskable delivery happens until `iret_i` is pulsed. One qualified edge that arrives meanwhile is delivered after that pulse, and any further edges from the same service period are dropped.
- R5: While `int_en_i` is 0, a high maskable input starts no acknowledge request.
- R6: A maskable request that is taken raises `ack_req_o` twice. Each request stays high until `ack_done_i` is sampled high, and `ack_req_o` is low for one cycle between the two requests.
- R7: If both kinds of interrupt are pending at the same decision point, the non-maskable one is delivered first, before any acknowledge request starts.
- R8: While `hold_ack_i` is 1, no acknowledge request starts and no non-maskable delivery happens. A qualified edge that arrives during hold is delivered after hold ends.
- R9: Each delivery drives `vec_valid_o` high for exactly one clock.
- R10: A maskable delivery has `vec_is_nmi_o` = 0, and `vec_o` equals `ack_data_i` as sampled with the second done strobe. Data presented with the first done strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| nmi_i | input | 1 | Non-maskable request, asynchronous, rising-edge |
| intr_i | input | 1 | Maskable request, asynchronous level |
| int_en_i | input | 1 | Interrupt-enable flag from the core |
| hold_ack_i | input | 1 | Bus granted to another master |
| iret_i | input | 1 | Return-from-interrupt strobe from the core |
| ack_req_o | output | 1 | Request for one interrupt-acknowledge bus cycle |
| ack_done_i | input | 1 | Bus engine has finished the current acknowledge cycle |
| ack_data_i | input | VEC_W | Data lines 7:0 seen at the end of an acknowledge cycle |
| vec_o | output | VEC_W | Delivered vector number |
| vec_valid_o | output | 1 | One-clock strobe marking a delivery |
| vec_is_nmi_o | output | 1 | Delivery is non-maskable |

## Verification
The assertions assume that the bus engine raises `ack_done_i` only while `ack_req_o` is high. They also assume that `iret_i` and `int_en_i` are synchronous to the clock. The stimulus keeps to both assumptions: the bench answers a request only after it has seen `ack_req_o` high, and it changes every input only on the falling edge. The checks on hold and ordering rely on `hold_ack_i` being level-stable for many cycles, and the bench holds it for well over the qualification time of the non-maskable edge.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [1:0] {
    ACK_IDLE = 2'd0,
    ACK_FIRST = 2'd1,
    ACK_GAP = 2'd2,
    ACK_SECOND = 2'd3
  } ack_state_e;

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = chain_q[STAGES-1];
endmodule

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_nmi_qual.sv
module irq_nmi_qual #(
  parameter int unsigned MIN_LOW  = 8,
  parameter int unsigned MIN_HIGH = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic edge_o
);
  localparam int unsigned MAXW = (MIN_LOW > MIN_HIGH) ? MIN_LOW : MIN_HIGH;
  localparam int unsigned CW   = $clog2(MAXW + 1);
  localparam logic [CW-1:0] LOW_TOP  = CW'(MIN_LOW);
  localparam logic [CW-1:0] HIGH_TOP = CW'(MIN_HIGH);
  localparam logic [CW-1:0] HIGH_HIT = CW'(MIN_HIGH - 1);

  logic [CW-1:0] low_cnt_q, low_cnt_n;
  logic [CW-1:0] high_cnt_q, high_cnt_n;
  logic          armed_q, armed_n;

  always_comb begin
    edge_o     = 1'b0;
    low_cnt_n  = low_cnt_q;
    high_cnt_n = high_cnt_q;
    armed_n    = armed_q;
    if (!lvl_i) begin
      // low phase: count toward the minimum low width
      high_cnt_n = '0;
      low_cnt_n  = (low_cnt_q == LOW_TOP) ? low_cnt_q : low_cnt_q + 1'b1;
      armed_n    = (low_cnt_n == LOW_TOP);
    end else begin
      // high phase: fire once the minimum high width is reached
      low_cnt_n  = '0;
      high_cnt_n = (high_cnt_q == HIGH_TOP) ? high_cnt_q : high_cnt_q + 1'b1;
      edge_o     = armed_q && (high_cnt_q == HIGH_HIT);
      armed_n    = armed_q && !edge_o;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt_q  <= '0;
      high_cnt_q <= '0;
      armed_q    <= 1'b0;
    end else begin
      low_cnt_q  <= low_cnt_n;
      high_cnt_q <= high_cnt_n;
      armed_q    <= armed_n;
    end
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned VEC_W   = 8,
  parameter int unsigned NMI_VEC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             nmi_edge_i,
  input  logic             intr_lvl_i,
  input  logic             int_en_i,
  input  logic             hold_i,
  input  logic             iret_i,
  input  logic             ack_done_i,
  input  logic [VEC_W-1:0] ack_data_i,
  output logic             ack_req_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             vec_valid_o,
  output logic             vec_nmi_o
);
  localparam logic [VEC_W-1:0] NMI_CODE = VEC_W'(NMI_VEC);

  ack_state_e       state_q, state_n;
  logic             pend_q, pend_n;
  logic             busy_q, busy_n;
  logic             valid_q, valid_n;
  logic             nmi_q, nmi_n;
  logic [VEC_W-1:0] vec_q, vec_n;
  logic             nmi_go, intr_go, second_done;

  always_comb begin
    nmi_go      = (state_q == ACK_IDLE) && !hold_i && pend_q && !busy_q;
    intr_go     = (state_q == ACK_IDLE) && !hold_i && !nmi_go && intr_lvl_i && int_en_i;
    second_done = (state_q == ACK_SECOND) && ack_done_i;

    state_n = state_q;
    unique case (state_q)
      ACK_IDLE:   if (intr_go) state_n = ACK_FIRST;
      ACK_FIRST:  if (ack_done_i) state_n = ACK_GAP;
      ACK_GAP:    state_n = ACK_SECOND;
      ACK_SECOND: if (ack_done_i) state_n = ACK_IDLE;
      default:    state_n = ACK_IDLE;
    endcase

    // a new edge in the same cycle as a delivery stays pending
    if (nmi_edge_i)  pend_n = 1'b1;
    else if (nmi_go) pend_n = 1'b0;
    else             pend_n = pend_q;

    if (nmi_go)      busy_n = 1'b1;
    else if (iret_i) busy_n = 1'b0;
    else             busy_n = busy_q;

    valid_n = nmi_go || second_done;
    nmi_n   = nmi_q;
    vec_n   = vec_q;
    if (nmi_go) begin
      nmi_n = 1'b1;
      vec_n = NMI_CODE;
    end else if (second_done) begin
      nmi_n = 1'b0;
      vec_n = ack_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ACK_IDLE;
      pend_q  <= 1'b0;
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_n;
      pend_q  <= pend_n;
      busy_q  <= busy_n;
      valid_q <= valid_n;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q <= '0;
      nmi_q <= 1'b0;
    end else if (valid_n) begin
      vec_q <= vec_n;
      nmi_q <= nmi_n;
    end
  end

  assign ack_req_o   = (state_q == ACK_FIRST) || (state_q == ACK_SECOND);
  assign vec_o       = vec_q;
  assign vec_valid_o = valid_q;
  assign vec_nmi_o   = nmi_q;
endmodule

// File: rtl/irq_front_end.sv
module irq_front_end #(
  parameter int unsigned VEC_W        = 8,
  parameter int unsigned NMI_VEC      = 2,
  parameter int unsigned NMI_MIN_LOW  = 8,
  parameter int unsigned NMI_MIN_HIGH = 8,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             nmi_i,
  input  logic             intr_i,
  input  logic             int_en_i,
  input  logic             hold_ack_i,
  input  logic             iret_i,
  output logic             ack_req_o,
  input  logic             ack_done_i,
  input  logic [VEC_W-1:0] ack_data_i,
  output logic [VEC_W-1:0] vec_o,
  output logic             vec_valid_o,
  output logic             vec_is_nmi_o
);
  logic       rst_n;
  logic [1:0] pins_s;
  logic       nmi_edge;

  irq_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n)
  );

  irq_sync #(.W(2), .STAGES(SYNC_STAGES)) pin_sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .d_i    ({intr_i, nmi_i}),
    .q_o    (pins_s)
  );

  irq_nmi_qual #(.MIN_LOW(NMI_MIN_LOW), .MIN_HIGH(NMI_MIN_HIGH)) nmi_qual_i (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .lvl_i  (pins_s[0]),
    .edge_o (nmi_edge)
  );

  irq_ctrl #(.VEC_W(VEC_W), .NMI_VEC(NMI_VEC)) ctrl_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .nmi_edge_i  (nmi_edge),
    .intr_lvl_i  (pins_s[1]),
    .int_en_i    (int_en_i),
    .hold_i      (hold_ack_i),
    .iret_i      (iret_i),
    .ack_done_i  (ack_done_i),
    .ack_data_i  (ack_data_i),
    .ack_req_o   (ack_req_o),
    .vec_o       (vec_o),
    .vec_valid_o (vec_valid_o),
    .vec_nmi_o   (vec_is_nmi_o)
  );
endmodule

// File: rtl/irq_front_end_chk.sv
module irq_front_end_chk #(
  parameter int unsigned VEC_W   = 8,
  parameter int unsigned NMI_VEC = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hold_ack_i,
  input logic             int_en_i,
  input logic             iret_i,
  input logic             ack_req_o,
  input logic             ack_done_i,
  input logic [VEC_W-1:0] vec_o,
  input logic             vec_valid_o,
  input logic             vec_is_nmi_o
);
  logic in_srv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          in_srv_q <= 1'b0;
    else if (iret_i)                      in_srv_q <= 1'b0;
    else if (vec_valid_o && vec_is_nmi_o) in_srv_q <= 1'b1;
  end

  AST_NMI_VECTOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o && vec_is_nmi_o |-> vec_o == VEC_W'(NMI_VEC)); // R2

  AST_NMI_ONCE_PER_SERVICE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o && vec_is_nmi_o |-> !in_srv_q); // R4

  AST_ACK_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_req_o) |-> $past(int_en_i)); // R5

  AST_ACK_HELD_TO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_req_o && !ack_done_i |=> ack_req_o); // R6

  AST_ACK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_req_o && ack_done_i |=> !ack_req_o); // R6

  AST_NO_ACK_START_IN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_req_o) |-> !$past(hold_ack_i)); // R8

  AST_NO_NMI_IN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o && vec_is_nmi_o |-> !$past(hold_ack_i)); // R8

  AST_VALID_EXCLUDES_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> !ack_req_o); // R9

  AST_INTR_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o && !vec_is_nmi_o |-> $past(ack_req_o && ack_done_i)); // R10
endmodule

bind irq_front_end irq_front_end_chk #(.VEC_W(VEC_W), .NMI_VEC(NMI_VEC)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .hold_ack_i   (hold_ack_i),
  .int_en_i     (int_en_i),
  .iret_i       (iret_i),
  .ack_req_o    (ack_req_o),
  .ack_done_i   (ack_done_i),
  .vec_o        (vec_o),
  .vec_valid_o  (vec_valid_o),
  .vec_is_nmi_o (vec_is_nmi_o)
);

// File: tb/irq_front_end_tb_top.sv
`timescale 1ns/1ps
module irq_front_end_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       nmi = 1'b0, intr = 1'b0, int_en = 1'b0, hold = 1'b0, iret = 1'b0;
  logic       ack_req, ack_done = 1'b0;
  logic [7:0] ack_data = 8'h00;
  logic [7:0] vec;
  logic       vec_valid, vec_nmi;

  int checks = 0, fails = 0, cyc = 0;
  int nmi_cnt = 0, intr_cnt = 0, ack_rises = 0;
  logic [7:0] last_nmi_vec = 8'h00, last_intr_vec = 8'h00;
  logic ack_prev = 1'b0;

  always #2.5 clk = ~clk;

  irq_front_end dut_i (
    .clk_i(clk), .rst_ni(rst_n), .nmi_i(nmi), .intr_i(intr), .int_en_i(int_en),
    .hold_ack_i(hold), .iret_i(iret), .ack_req_o(ack_req), .ack_done_i(ack_done),
    .ack_data_i(ack_data), .vec_o(vec), .vec_valid_o(vec_valid), .vec_is_nmi_o(vec_nmi)
  );

  // event monitor, samples away from the active edge
  always @(negedge clk) begin
    if (vec_valid === 1'b1) begin
      if (vec_nmi) begin nmi_cnt++; last_nmi_vec = vec; end
      else begin intr_cnt++; last_intr_vec = vec; end
    end
    if (ack_req === 1'b1 && !ack_prev) ack_rises++;
    ack_prev = (ack_req === 1'b1);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: act=%0d cycles exp=<150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic nmi_shape(input int lo, input int hi);
    nmi = 1'b0; idle(lo);
    nmi = 1'b1; idle(hi);
  endtask

  task automatic do_iret;
    iret = 1'b1; idle(1); iret = 1'b0; idle(2);
  endtask

  task automatic wait_req(input string req, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (ack_req) begin ok = 1'b1; break; end
    end
    chk(ok, req, int'(ok), 1);
  endtask

  task automatic done_pulse(input logic [7:0] d);
    ack_done = 1'b1; ack_data = d; idle(1);
    ack_done = 1'b0; ack_data = 8'h00;
  endtask

  task automatic t_reset;
    idle(3);
    chk(ack_req == 1'b0 && vec_valid == 1'b0, "R1 in reset", int'({ack_req, vec_valid}), 0);
    rst_n = 1'b1; idle(4);
    chk(ack_req == 1'b0 && vec_valid == 1'b0, "R1 after release", int'({ack_req, vec_valid}), 0);
  endtask

  task automatic t_nmi_basic;
    int n0 = nmi_cnt, a0 = ack_rises;
    nmi_shape(12, 12); idle(10);
    chk(nmi_cnt - n0 == 1, "R2/R9 one nmi delivery", nmi_cnt - n0, 1);
    chk(last_nmi_vec == 8'd2, "R2 nmi vector", last_nmi_vec, 2);
    chk(ack_rises == a0, "R2 no ack cycles for nmi", ack_rises - a0, 0);
    do_iret();
  endtask

  task automatic t_nmi_short;
    int n0;
    nmi = 1'b0; idle(14);
    n0 = nmi_cnt;
    nmi_shape(12, 5); nmi = 1'b0; idle(20);
    chk(nmi_cnt == n0, "R3 short high ignored", nmi_cnt - n0, 0);
    nmi = 1'b1; idle(20); do_iret();
    n0 = nmi_cnt;
    nmi_shape(4, 16); idle(10);
    chk(nmi_cnt == n0, "R3 short low ignored", nmi_cnt - n0, 0);
    nmi = 1'b0; idle(4);
  endtask

  task automatic t_nmi_service;
    int n0 = nmi_cnt;
    nmi_shape(12, 12); idle(6);
    chk(nmi_cnt - n0 == 1, "R4 first delivery", nmi_cnt - n0, 1);
    nmi_shape(12, 12); nmi_shape(12, 12); idle(10);
    chk(nmi_cnt - n0 == 1, "R4 blocked in service", nmi_cnt - n0, 1);
    do_iret(); idle(6);
    chk(nmi_cnt - n0 == 2, "R4 remembered edge after return", nmi_cnt - n0, 2);
    do_iret(); idle(30);
    chk(nmi_cnt - n0 == 2, "R4 extra edge dropped", nmi_cnt - n0, 2);
    nmi = 1'b0; idle(4);
  endtask

  task automatic t_intr_masked;
    int a0 = ack_rises, i0 = intr_cnt;
    int_en = 1'b0; intr = 1'b1; idle(30);
    chk(ack_rises == a0 && intr_cnt == i0, "R5 masked request ignored", ack_rises - a0, 0);
    intr = 1'b0; idle(4);
  endtask

  task automatic serve_pair(input logic [7:0] d1, input logic [7:0] d2, input string req);
    bit ok;
    wait_req(req, ok);
    if (!ok) return;
    intr = 1'b0;
    idle(3);
    chk(ack_req == 1'b1, "R6 first request held", int'(ack_req), 1);
    done_pulse(d1);
    chk(ack_req == 1'b0, "R6 gap between requests", int'(ack_req), 0);
    wait_req(req, ok);
    if (!ok) return;
    idle(2);
    chk(ack_req == 1'b1, "R6 second request held", int'(ack_req), 1);
    done_pulse(d2);
  endtask

  task automatic t_intr(input logic [7:0] d1, input logic [7:0] d2);
    int a0 = ack_rises, i0 = intr_cnt;
    int_en = 1'b1; intr = 1'b1;
    serve_pair(d1, d2, "R6 request seen");
    int_en = 1'b0; idle(6);
    chk(ack_rises - a0 == 2, "R6 two acknowledge requests", ack_rises - a0, 2);
    chk(intr_cnt - i0 == 1, "R9 one maskable delivery", intr_cnt - i0, 1);
    chk(last_intr_vec == d2, "R10 vector from second cycle", last_intr_vec, d2);
  endtask

  task automatic t_hold_priority;
    int n0 = nmi_cnt, a0 = ack_rises, i0 = intr_cnt;
    bit nmi_first = 1'b0, seen = 1'b0;
    hold = 1'b1; int_en = 1'b1; intr = 1'b1;
    nmi_shape(12, 12); idle(15);
    chk(nmi_cnt == n0 && ack_rises == a0, "R8 nothing during hold",
        (nmi_cnt - n0) + (ack_rises - a0), 0);
    hold = 1'b0;
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge clk);
      if (ack_req) seen = 1'b1;
      else if (vec_valid) begin seen = 1'b1; nmi_first = vec_nmi; end
    end
    chk(nmi_first, "R7 nmi before acknowledge", int'(nmi_first), 1);
    serve_pair(8'h11, 8'hC5, "R8 request after hold");
    int_en = 1'b0; idle(6);
    chk(nmi_cnt - n0 == 1, "R8 held edge delivered", nmi_cnt - n0, 1);
    chk(intr_cnt - i0 == 1 && last_intr_vec == 8'hC5, "R10 vector after hold",
        last_intr_vec, 8'hC5);
    do_iret(); nmi = 1'b0; idle(4);
  endtask

  initial begin
    t_reset();
    t_nmi_basic();
    t_nmi_short();
    t_nmi_service();
    t_intr_masked();
    t_intr(8'h5A, 8'h3C);
    t_intr(8'hFF, 8'h00);
    t_hold_priority();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule